// File: doc/BRIEF.md
# Supply Fault Reset Sequencer

This block turns the over-voltage and under-voltage flags of two supply rails into a complementary reset pair and a complementary enable pair. The four flags arrive already synchronized to the system clock and are combined into one fault. A fault must persist for a set number of clock cycles before it counts, which filters out short glitches. Once reset is asserted, it stays asserted for a hold delay that starts when the fault goes away. Any fault cycle that appears during the hold restarts the delay. As a result, the total hold can be longer than one delay.

While reset is active, the block tells the watchdog to stay in its initial state. The enable pair follows the watchdog OK input, and it is forced inactive whenever reset is active. The relay and FET drive requests pass to their outputs only while enable is active. The debounce length and the delay length are parameters counted in clock cycles. An asynchronous power-on reset puts the block into reset, and a full delay runs before the first release.

Top module: `supply_reset_seq`

## Requirements
- R1: If no more than DEBOUNCE_CYC-1 consecutive sampled cycles show a fault, the fault has no effect on any output.
- R2: A fault sampled on DEBOUNCE_CYC consecutive rising edges sets rst_pos high and rst_neg low at the last of those edges.
- R3: After the fault clears, reset is released at the DELAY_CYC-th consecutive fault-free rising edge, and not before.
- R4: While reset is held, any single sampled fault cycle restarts the hold. Release then needs DELAY_CYC further fault-free edges.
- R5: rst_neg is always the complement of rst_pos.
- R6: wd_hold is high exactly while reset is active, so that the watchdog is held in its initial state.
- R7: en_pos is high only when wd_ok is high and reset is inactive. en_neg is always the complement of en_pos.
- R8: relay_drv equals relay_req AND en_pos, and fet_drv equals fet_req AND en_pos. A low (default) request means the driver is off.
- R9: While rst_n is low, reset is active. After rst_n rises, reset is released at the DELAY_CYC-th rising edge if no fault occurs.
- R10: Each of the four flags (ov_5v, uv_5v, ov_3v3, uv_3v3) counts as a fault on its own.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous power-on reset, active low |
| ov_5v | input | 1 | Over-voltage flag, 5 V rail |
| uv_5v | input | 1 | Under-voltage flag, 5 V rail |
| ov_3v3 | input | 1 | Over-voltage flag, 3.3 V rail |
| uv_3v3 | input | 1 | Under-voltage flag, 3.3 V rail |
| wd_ok | input | 1 | Watchdog OK status |
| relay_req | input | 1 | Relay drive request |
| fet_req | input | 1 | FET drive request |
| rst_pos | output | 1 | Reset, active high |
| rst_neg | output | 1 | Reset, active low |
| en_pos | output | 1 | Enable, active high |
| en_neg | output | 1 | Enable, active low |
| relay_drv | output | 1 | Gated relay drive |
| fet_drv | output | 1 | Gated FET drive |
| wd_hold | output | 1 | Holds the watchdog in its initial state |

## Verification
The reset pair and wd_hold change at the rising edge on which the DEBOUNCE_CYC-th consecutive fault sample is taken. They fall at the edge of the DELAY_CYC-th fault-free sample. The enable pair and both drives are combinational functions of wd_ok, the requests and the reset register, so they settle in the same cycle as their inputs. The bench drives every input just after a falling edge and counts rising edges from that point. Each check falls one edge short of a transition and then exactly on it, and is sampled at the next falling edge. The combinational gating is checked a short delay after its inputs are driven.

// File: rtl/supply_reset_seq.sv
module supply_reset_seq #(
  parameter int DEBOUNCE_CYC = 8,
  parameter int DELAY_CYC    = 32
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ov_5v,
  input  logic uv_5v,
  input  logic ov_3v3,
  input  logic uv_3v3,
  input  logic wd_ok,
  input  logic relay_req,
  input  logic fet_req,
  output logic rst_pos,
  output logic rst_neg,
  output logic en_pos,
  output logic en_neg,
  output logic relay_drv,
  output logic fet_drv,
  output logic wd_hold
);
  localparam int DBW = (DEBOUNCE_CYC > 2) ? $clog2(DEBOUNCE_CYC) : 1;
  localparam int DLW = (DELAY_CYC > 2) ? $clog2(DELAY_CYC) : 1;
  localparam logic [DBW-1:0] DB_LAST = DBW'(DEBOUNCE_CYC - 1);
  localparam logic [DLW-1:0] DL_LAST = DLW'(DELAY_CYC - 1);

  logic           fault, trip, in_reset;
  logic [DBW-1:0] db_cnt;
  logic [DLW-1:0] dl_cnt;

  assign fault = ov_5v | uv_5v | ov_3v3 | uv_3v3;
  assign trip  = fault && (db_cnt == DB_LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      db_cnt <= '0;
    else if (!fault)
      db_cnt <= '0;
    else if (db_cnt != DB_LAST)
      db_cnt <= db_cnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      in_reset <= 1'b1;
      dl_cnt   <= '0;
    end else if (trip) begin
      in_reset <= 1'b1;
      dl_cnt   <= '0;
    end else if (in_reset) begin
      if (fault)
        dl_cnt <= '0;
      else if (dl_cnt == DL_LAST) begin
        in_reset <= 1'b0;
        dl_cnt   <= '0;
      end else
        dl_cnt <= dl_cnt + 1'b1;
    end
  end

  assign rst_pos   = in_reset;
  assign rst_neg   = ~in_reset;
  assign wd_hold   = in_reset;
  assign en_pos    = wd_ok & ~in_reset;
  assign en_neg    = ~en_pos;
  assign relay_drv = relay_req & en_pos;
  assign fet_drv   = fet_req & en_pos;
endmodule

module supply_reset_seq_chk (
  input logic clk,
  input logic rst_n,
  input logic ov_5v,
  input logic uv_5v,
  input logic ov_3v3,
  input logic uv_3v3,
  input logic wd_ok,
  input logic relay_req,
  input logic fet_req,
  input logic rst_pos,
  input logic rst_neg,
  input logic en_pos,
  input logic en_neg,
  input logic relay_drv,
  input logic fet_drv,
  input logic wd_hold
);
  logic any_fault;
  assign any_fault = ov_5v | uv_5v | ov_3v3 | uv_3v3;

  assert_reset_pair_R5: assert property (@(posedge clk) disable iff (!rst_n)
    rst_neg == !rst_pos);
  assert_wd_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    wd_hold == rst_pos);
  assert_enable_gate_R7: assert property (@(posedge clk) disable iff (!rst_n)
    en_pos |-> (wd_ok && !rst_pos && !en_neg));
  assert_drive_gate_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (relay_drv || fet_drv) |-> en_pos);
  assert_trip_cause_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_pos) |-> $past(any_fault));
  assert_release_clean_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rst_pos) |-> !$past(any_fault));
endmodule

bind supply_reset_seq supply_reset_seq_chk u_chk (.*);

// File: tb/tb_supply_reset_seq.sv
module tb_supply_reset_seq;
  localparam int DEB = 8;
  localparam int DLY = 32;

  logic clk = 1'b0, rst_n = 1'b0;
  logic ov_5v = 0, uv_5v = 0, ov_3v3 = 0, uv_3v3 = 0;
  logic wd_ok = 0, relay_req = 0, fet_req = 0;
  logic rst_pos, rst_neg, en_pos, en_neg, relay_drv, fet_drv, wd_hold;
  int checks = 0, errors = 0;

  always #4 clk = ~clk;

  supply_reset_seq #(.DEBOUNCE_CYC(DEB), .DELAY_CYC(DLY)) dut (.*);

  // {wd_ok, relay_req, fet_req, exp_en, exp_relay, exp_fet}
  localparam logic [5:0] VEC [8] = '{
    6'b000_000, 6'b001_000, 6'b010_000, 6'b011_000,
    6'b100_100, 6'b101_101, 6'b110_110, 6'b111_111
  };

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%b expected=%b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic set_flag(input int idx, input logic v);
    case (idx)
      0: ov_5v = v;
      1: uv_5v = v;
      2: ov_3v3 = v;
      default: uv_3v3 = v;
    endcase
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    step(3);
    chk("R9 reset rst_pos", rst_pos, 1'b1);
    chk("R5 reset rst_neg", rst_neg, 1'b0);
    chk("R7 reset en_pos", en_pos, 1'b0);
    chk("R7 reset en_neg", en_neg, 1'b1);
    chk("R6 reset wd_hold", wd_hold, 1'b1);
    rst_n = 1'b1;
    wd_ok = 1'b1;
    relay_req = 1'b1;
    step(DLY - 1);
    chk("R9 still held", rst_pos, 1'b1);
    chk("R8 relay off in reset", relay_drv, 1'b0);
    step(1);
    chk("R9 released", rst_pos, 1'b0);
    chk("R6 hold released", wd_hold, 1'b0);

    for (int i = 0; i < 8; i++) begin
      {wd_ok, relay_req, fet_req} = VEC[i][5:3];
      #1;
      chk("R7 table en_pos", en_pos, VEC[i][2]);
      chk("R7 table en_neg", en_neg, ~VEC[i][2]);
      chk("R8 table relay", relay_drv, VEC[i][1]);
      chk("R8 table fet", fet_drv, VEC[i][0]);
      step(1);
    end

    wd_ok = 1; relay_req = 1; fet_req = 1;
    ov_5v = 1;
    step(DEB - 1);
    ov_5v = 0;
    chk("R1 short glitch rst", rst_pos, 1'b0);
    chk("R1 short glitch en", en_pos, 1'b1);
    step(4);
    chk("R1 after glitch rst", rst_pos, 1'b0);
    chk("R1 after glitch fet", fet_drv, 1'b1);

    uv_3v3 = 1;
    step(DEB - 1);
    chk("R2 one short", rst_pos, 1'b0);
    step(1);
    chk("R2 tripped rst_pos", rst_pos, 1'b1);
    chk("R5 tripped rst_neg", rst_neg, 1'b0);
    chk("R7 tripped en_pos", en_pos, 1'b0);
    chk("R8 tripped relay", relay_drv, 1'b0);
    step(20);
    uv_3v3 = 0;
    step(DLY - 1);
    chk("R3 held one short", rst_pos, 1'b1);
    step(1);
    chk("R3 released", rst_pos, 1'b0);
    chk("R7 re-enabled", en_pos, 1'b1);

    ov_3v3 = 1;
    step(DEB);
    ov_3v3 = 0;
    chk("R4 tripped", rst_pos, 1'b1);
    step(10);
    uv_5v = 1;
    step(1);
    uv_5v = 0;
    step(DLY - 11);
    chk("R4 past first delay", rst_pos, 1'b1);
    step(10);
    chk("R4 stretched hold", rst_pos, 1'b1);
    step(1);
    chk("R4 released after restart", rst_pos, 1'b0);

    for (int f = 0; f < 4; f++) begin
      set_flag(f, 1'b1);
      step(DEB);
      chk("R10 flag trips", rst_pos, 1'b1);
      set_flag(f, 1'b0);
      step(DLY);
      chk("R10 flag released", rst_pos, 1'b0);
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule